// File: doc/BRIEF.md
# Serial Lane Bring-Up Sequencer

This block is a hardware controller that takes one lane of a high-speed serial transceiver from reset to a working SATA link without any software involvement. After a `start` pulse it becomes the only master of a byte-wide register bus. On that bus it issues a fixed recipe of writes and status polls. The recipe changes with the link generation (1, 2 or 3) and with a transmit-polarity-invert option. Both are captured when `start` is accepted.

Each status poll is bounded by a cycle budget. If the budget runs out, the run stops and `error` stays high until the next accepted start. A run that completes raises `done` for a single cycle. One step of the recipe is a settling pause. Its length, like the poll budget, is a parameter measured in clock cycles.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is held and after it is released, `done` and `error` are low and neither bus strobe is asserted until a start is accepted.
- R2: The opening writes, as (address, data), are: (0x00, 0x96); then (0x02, 0x20) only when `tx_inv` is 1; then (0x10, 0x01) and (0x72, 0x40); then (0x12, speed code). The speed code carries generation minus 1 in both bits [1:0] and bits [4:3].
- R3: The sequencer then reads 0x01 repeatedly until bits 1 and 0 both read 0. All other bits of that register are ignored.
- R4: It writes 0x41 with 0x1E for generation 1 and with 0x0F otherwise. For generations 1 and 2 it then writes (0x42, 0x33), (0x51, 0x02) and (0x47, 0x2A).
- R5: It writes (0x40, 0x13), then reads 0x40 until bits 3 and 2 are both 1.
- R6: It writes the buffer settings:
  - Generation 3: (0x20, 0x12), (0x21, 0x64), (0x22, 0x02), (0x23, 0x00), (0x25, 0x31).
  - Generation 2: (0x20, 0x01), (0x21, 0x04), (0x22, 0x02), (0x25, 0x11).
  - Generation 1: (0x20, 0x10), (0x21, 0x03), (0x22, 0x04).
- R7: It writes (0x00, 0x10). More than DELAY_CYC cycles then pass before the next bus access is presented.
- R8: It writes 0x03, 0x63, 0x00 and 0xF1 to 0x56, 0x57, 0x58 and 0x59, in that order. It then writes 0x50 with 0x8D for generation 1 and with 0xCD otherwise.
- R9: It reads 0x01 until bits 1 and 0 are both 1. It then writes (0x10, 0x00), (0x72, 0x00), (0x00, 0x10), (0x02, 0x08 with bit 5 set when `tx_inv` is 1), (0x86, 0x61) and (0x00, 0x00).
- R10: `gen_sel` values 2 and 3 select generations 2 and 3. Values 0 and 1 both select generation 1.
- R11: A poll read that completes unsatisfied after TIMEOUT_CYC or more cycles in that poll ends the run with `error` high and no further bus access. A read that completes satisfied always advances, even in the cycle the budget is reached.
- R12: `done` is high for exactly one cycle after the last write. `error` stays high until the next accepted start, which clears it.
- R13: A `start` while a run is in progress is ignored: the write stream and the captured generation and polarity do not change.
- R14: A strobe holds its address and write data until the cycle `ready` is high. `bus_wr` and `bus_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| gen_sel | input | 2 | Link generation request (2, 3; others mean 1) |
| tx_inv | input | 1 | Request transmit polarity inversion |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Poll timeout; held until next accepted start |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid when ready is high |
| bus_ready | input | 1 | Access completes in a cycle where this is high |

## Verification
The poll satisfaction test and the timeout test can land in the same cycle. This happens when the status bits turn good on exactly the read that reaches the budget.

The bench provokes the tie with a zero-wait responder. The responder holds the first poll unsatisfied for exactly TIMEOUT_CYC reads and satisfies the next read; that run must finish with `done`. A second run holds the poll unsatisfied for one read longer. That run must stop with `error` and issue no further writes.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   localparam int AW     = 8;
   localparam int DW     = 8;
   localparam int STEP_W = 5;

   typedef enum logic [2:0] {
      OP_WR,
      OP_POLL_CLR,
      OP_POLL_SET,
      OP_PAUSE,
      OP_SKIP,
      OP_END
   } op_kind_e;

   typedef enum logic [1:0] {
      LINK_G1 = 2'd1,
      LINK_G2 = 2'd2,
      LINK_G3 = 2'd3
   } link_gen_e;

   typedef struct packed {
      op_kind_e         kind;
      logic [AW-1:0]    addr;
      logic [DW-1:0]    data;   // write value, or mask for polls
   } seq_op_t;

   function automatic seq_op_t mk_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      return '{kind: OP_WR, addr: a, data: d};
   endfunction

   function automatic seq_op_t mk_poll(input op_kind_e k, input logic [AW-1:0] a,
                                       input logic [DW-1:0] m);
      return '{kind: k, addr: a, data: m};
   endfunction

   function automatic seq_op_t mk_skip();
      return '{kind: OP_SKIP, addr: '0, data: '0};
   endfunction

endpackage

// File: rtl/phy_seq_step_rom.sv
module phy_seq_step_rom
   import phy_seq_pkg::*;
(
   input  logic [STEP_W-1:0] idx,
   input  link_gen_e         gen,
   input  logic              inv,
   output seq_op_t           op
);

   logic [1:0]    spd;
   logic          g1, g3;
   logic [DW-1:0] ctl_fin;

   assign g1      = (gen == LINK_G1);
   assign g3      = (gen == LINK_G3);
   assign spd     = gen - 2'd1;
   assign ctl_fin = {2'b00, inv, 5'b01000};

   always_comb begin
      op = mk_skip();
      unique case (idx)
         5'd0:  op = mk_wr(8'h00, 8'h96);
         5'd1:  op = inv ? mk_wr(8'h02, 8'h20) : mk_skip();
         5'd2:  op = mk_wr(8'h10, 8'h01);
         5'd3:  op = mk_wr(8'h72, 8'h40);
         5'd4:  op = mk_wr(8'h12, {3'b000, spd, 1'b0, spd});
         5'd5:  op = mk_poll(OP_POLL_CLR, 8'h01, 8'h03);
         5'd6:  op = mk_wr(8'h41, g1 ? 8'h1E : 8'h0F);
         5'd7:  op = g3 ? mk_skip() : mk_wr(8'h42, 8'h33);
         5'd8:  op = g3 ? mk_skip() : mk_wr(8'h51, 8'h02);
         5'd9:  op = g3 ? mk_skip() : mk_wr(8'h47, 8'h2A);
         5'd10: op = mk_wr(8'h40, 8'h13);
         5'd11: op = mk_poll(OP_POLL_SET, 8'h40, 8'h0C);
         5'd12: op = mk_wr(8'h20, g3 ? 8'h12 : (g1 ? 8'h10 : 8'h01));
         5'd13: op = mk_wr(8'h21, g3 ? 8'h64 : (g1 ? 8'h03 : 8'h04));
         5'd14: op = mk_wr(8'h22, g1 ? 8'h04 : 8'h02);
         5'd15: op = g3 ? mk_wr(8'h23, 8'h00) : mk_skip();
         5'd16: op = g1 ? mk_skip() : mk_wr(8'h25, g3 ? 8'h31 : 8'h11);
         5'd17: op = mk_wr(8'h00, 8'h10);
         5'd18: op = '{kind: OP_PAUSE, addr: '0, data: '0};
         5'd19: op = mk_wr(8'h56, 8'h03);
         5'd20: op = mk_wr(8'h57, 8'h63);
         5'd21: op = mk_wr(8'h58, 8'h00);
         5'd22: op = mk_wr(8'h59, 8'hF1);
         5'd23: op = mk_wr(8'h50, g1 ? 8'h8D : 8'hCD);
         5'd24: op = mk_poll(OP_POLL_SET, 8'h01, 8'h03);
         5'd25: op = mk_wr(8'h10, 8'h00);
         5'd26: op = mk_wr(8'h72, 8'h00);
         5'd27: op = mk_wr(8'h00, 8'h10);
         5'd28: op = mk_wr(8'h02, ctl_fin);
         5'd29: op = mk_wr(8'h86, 8'h61);
         5'd30: op = mk_wr(8'h00, 8'h00);
         default: op = '{kind: OP_END, addr: '0, data: '0};
      endcase
   end

endmodule

// File: rtl/phy_seq_cycle_timer.sv
module phy_seq_cycle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (cnt != '1)    cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
   import phy_seq_pkg::*;
#(
   parameter int TIMEOUT_CYC = 10_000_000,
   parameter int DELAY_CYC   = 12_500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    gen_sel,
   input  logic          tx_inv,
   output logic          done,
   output logic          error,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_wr,
   output logic          bus_rd,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ready
);

   localparam int LIMIT = (TIMEOUT_CYC > DELAY_CYC) ? TIMEOUT_CYC : DELAY_CYC;
   localparam int CNT_W = $clog2(LIMIT + 1);

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 1");
      end
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("DELAY_CYC must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSE} seq_state_e;

   seq_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   link_gen_e         gen_q;
   logic              inv_q;
   seq_op_t           op;
   logic [CNT_W-1:0]  tcnt;
   logic              is_poll, poll_met, adv, go_pause, tmr_clr;
   logic              tmo_hit, pause_end, abort;

   phy_seq_step_rom u_rom (
      .idx (step_q),
      .gen (gen_q),
      .inv (inv_q),
      .op  (op)
   );

   phy_seq_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cnt   (tcnt)
   );

   assign is_poll   = (op.kind == OP_POLL_CLR) || (op.kind == OP_POLL_SET);
   assign poll_met  = (op.kind == OP_POLL_CLR) ? ((bus_rdata & op.data) == '0)
                                               : ((bus_rdata & op.data) == op.data);
   assign tmo_hit   = (tcnt >= CNT_W'(TIMEOUT_CYC));
   assign pause_end = (tcnt == CNT_W'(DELAY_CYC - 1));

   always_comb begin
      adv      = 1'b0;
      go_pause = 1'b0;
      abort    = 1'b0;
      if (state_q == ST_RUN) begin
         unique case (op.kind)
            OP_SKIP:  adv = 1'b1;
            OP_WR:    adv = bus_ready;
            OP_PAUSE: go_pause = 1'b1;
            OP_POLL_CLR, OP_POLL_SET: begin
               adv   = bus_ready && poll_met;
               abort = bus_ready && !poll_met && tmo_hit;
            end
            default: ;
         endcase
      end else if (state_q == ST_PAUSE) begin
         adv = pause_end;
      end
   end

   assign tmr_clr = adv || go_pause || (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         gen_q   <= LINK_G1;
         inv_q   <= 1'b0;
         done    <= 1'b0;
         error   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (adv) step_q <= step_q + 1'b1;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               step_q  <= '0;
               error   <= 1'b0;
               inv_q   <= tx_inv;
               gen_q   <= (gen_sel == 2'd3) ? LINK_G3 :
                          (gen_sel == 2'd2) ? LINK_G2 : LINK_G1;
            end
            ST_RUN: begin
               if (op.kind == OP_END) begin
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (go_pause) begin
                  state_q <= ST_PAUSE;
               end else if (abort) begin
                  error   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_PAUSE: if (pause_end) state_q <= ST_RUN;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_wr    = (state_q == ST_RUN) && (op.kind == OP_WR);
   assign bus_rd    = (state_q == ST_RUN) && is_poll;
   assign bus_addr  = (bus_wr || bus_rd) ? op.addr : '0;
   assign bus_wdata = bus_wr ? op.data : '0;

endmodule

// File: rtl/phy_seq_checks.sv
module phy_seq_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       done,
   input logic       error,
   input logic [7:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic       bus_ready
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R14

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata)); // R14

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr)); // R14

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !error); // R12

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start |=> error); // R12

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !bus_wr && !bus_rd); // R11

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_wr && !bus_rd); // R12

endmodule

bind phy_bringup_seq phy_seq_checks i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .error     (error),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_ready (bus_ready)
);

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;

   localparam int T_CYC = 20;
   localparam int D_CYC = 50;

   typedef struct {
      logic [7:0] addr;
      logic [7:0] data;
      string      tag;
   } exp_wr_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] gen_sel = 2'd1;
   logic       tx_inv = 1'b0;
   logic       done, error, bus_wr, bus_rd;
   logic [7:0] bus_addr, bus_wdata;
   logic [7:0] bus_rdata;
   logic       bus_ready = 1'b1;

   int   n_run = 0, n_fail = 0, cyc = 0;
   int   need_a = 1, need_b = 1, need_c = 1;
   int   rd_cnt = 0;
   bit   after50 = 1'b0;
   bit   zero_wait = 1'b1;
   int   done_cnt = 0;
   int   t_mark = -1;
   bit   finished = 1'b0;
   logic [7:0] lfsr = 8'h5A;
   string run_lbl = "reset";
   exp_wr_t q[$];

   always #4 clk = ~clk;

   phy_bringup_seq #(.TIMEOUT_CYC(T_CYC), .DELAY_CYC(D_CYC)) i_phy_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel), .tx_inv(tx_inv),
      .done(done), .error(error), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] actual=0x%0h expected=0x%0h", tag, run_lbl, act, exp);
      end
   endtask

   // Register responder: status reads satisfy after a programmed number of reads.
   always_comb begin
      if (bus_addr == 8'h40)
         bus_rdata = (rd_cnt >= need_b) ? 8'h3C : 8'h08;
      else if (bus_addr == 8'h01 && after50)
         bus_rdata = (rd_cnt >= need_c) ? 8'h03 : 8'hFD;
      else if (bus_addr == 8'h01)
         bus_rdata = (rd_cnt >= need_a) ? 8'hFC : 8'h02;
      else
         bus_rdata = 8'h00;
   end

   always @(posedge clk) begin
      if (start && !bus_wr && !bus_rd && !after50) rd_cnt <= 0;
      if (bus_wr && bus_ready) begin
         rd_cnt <= 0;
         if (bus_addr == 8'h50) after50 <= 1'b1;
      end else if (bus_rd && bus_ready) begin
         rd_cnt <= rd_cnt + 1;
      end
   end

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_ready = zero_wait ? 1'b1 : lfsr[0];
   end

   // Monitor: pops the expected write stream as writes complete.
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (done) done_cnt++;
         if (bus_wr && bus_ready) begin
            check(!bus_rd, "R14 strobes exclusive", int'(bus_rd), 0);
            if (t_mark >= 0) begin
               check(cyc - t_mark > D_CYC, "R7 settle gap", cyc - t_mark, D_CYC + 1);
               t_mark = -1;
            end
            if (bus_addr == 8'h00 && bus_wdata == 8'h10 && !after50) t_mark = cyc;
            if (q.size() == 0) begin
               check(1'b0, "R11 unexpected write", {bus_addr, bus_wdata}, 0);
            end else begin
               exp_wr_t e;
               e = q.pop_front();
               check(bus_addr == e.addr && bus_wdata == e.data, e.tag,
                     {bus_addr, bus_wdata}, {e.addr, e.data});
            end
         end
      end
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic push(input logic [7:0] a, input logic [7:0] d, input string tag);
      exp_wr_t e;
      e.addr = a; e.data = d; e.tag = tag;
      q.push_back(e);
   endtask

   // stage 0: abort at first poll, 1: abort at last poll, 2: full run
   task automatic build_expect(input int g, input bit inv, input int stage);
      int ge;
      logic [1:0] c;
      ge = (g == 2 || g == 3) ? g : 1;   // R10
      c  = 2'(ge - 1);
      q.delete();
      push(8'h00, 8'h96, "R2 reset write");
      if (inv) push(8'h02, 8'h20, "R2 polarity");
      push(8'h10, 8'h01, "R2 boundary");
      push(8'h72, 8'h40, "R2 clock force");
      push(8'h12, {3'b000, c, 1'b0, c}, "R2 speed code");
      if (stage == 0) return;
      push(8'h41, (ge == 1) ? 8'h1E : 8'h0F, "R4 ratio");
      if (ge != 3) begin
         push(8'h42, 8'h33, "R4 ref");
         push(8'h51, 8'h02, "R4 bypass");
         push(8'h47, 8'h2A, "R4 idll");
      end
      push(8'h40, 8'h13, "R5 comp start");
      if (ge == 3) begin
         push(8'h20, 8'h12, "R6"); push(8'h21, 8'h64, "R6"); push(8'h22, 8'h02, "R6");
         push(8'h23, 8'h00, "R6"); push(8'h25, 8'h31, "R6");
      end else if (ge == 2) begin
         push(8'h20, 8'h01, "R6"); push(8'h21, 8'h04, "R6"); push(8'h22, 8'h02, "R6");
         push(8'h25, 8'h11, "R6");
      end else begin
         push(8'h20, 8'h10, "R6"); push(8'h21, 8'h03, "R6"); push(8'h22, 8'h04, "R6");
      end
      push(8'h00, 8'h10, "R7 partial mode");
      push(8'h56, 8'h03, "R8"); push(8'h57, 8'h63, "R8");
      push(8'h58, 8'h00, "R8"); push(8'h59, 8'hF1, "R8");
      push(8'h50, (ge == 1) ? 8'h8D : 8'hCD, "R8 pll ctrl");
      if (stage == 1) return;
      push(8'h10, 8'h00, "R9"); push(8'h72, 8'h00, "R9"); push(8'h00, 8'h10, "R9");
      push(8'h02, inv ? 8'h28 : 8'h08, "R9 lock enable");
      push(8'h86, 8'h61, "R9"); push(8'h00, 8'h00, "R9");
   endtask

   task automatic run_seq(input string lbl, input logic [1:0] gs, input bit inv,
                          input int na, input int nb, input int nc, input bit zw,
                          input int stage, input bit poke);
      bit ended;
      run_lbl = lbl;
      build_expect(int'(gs), inv, stage);
      need_a = na; need_b = nb; need_c = nc;
      zero_wait = zw;
      done_cnt = 0;
      t_mark = -1;
      @(posedge clk); #1;
      after50 = 1'b0;
      start = 1'b1; gen_sel = gs; tx_inv = inv;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      check(error == 1'b0, "R12 error cleared by start", int'(error), 0);
      ended = 1'b0;
      for (int i = 0; i < 20000 && !ended; i++) begin
         if (poke && i == 10) begin
            @(posedge clk); #1;
            start = 1'b1; gen_sel = 2'd3; tx_inv = ~inv;   // R13: ignored
            @(posedge clk); #1;
            start = 1'b0;
         end
         @(negedge clk);
         if (done_cnt > 0 || error) ended = 1'b1;
      end
      repeat (6) @(negedge clk);
      if (stage == 2) begin
         check(done_cnt == 1, "R12 done pulse count", done_cnt, 1);
         check(error == 1'b0, "R11 no error on success", int'(error), 0);
      end else begin
         check(done_cnt == 0, "R11 no done on abort", done_cnt, 0);
         check(error == 1'b1, "R11 error on timeout", int'(error), 1);
      end
      check(q.size() == 0, "R2 write stream complete", q.size(), 0);
      check(!bus_wr && !bus_rd, "R11 bus idle after run", int'({bus_wr, bus_rd}), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!done && !error && !bus_wr && !bus_rd, "R1 in reset",
            int'({done, error, bus_wr, bus_rd}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!done && !error && !bus_wr && !bus_rd, "R1 idle after reset",
            int'({done, error, bus_wr, bus_rd}), 0);

      run_seq("R3 gen3", 2'd3, 1'b0, 2, 3, 2, 1'b1, 2, 1'b0);
      run_seq("R6 gen2 inv wait", 2'd2, 1'b1, 3, 1, 4, 1'b0, 2, 1'b0);
      run_seq("R4 gen1 wait", 2'd1, 1'b0, 1, 2, 1, 1'b0, 2, 1'b0);
      run_seq("R10 gen0 inv", 2'd0, 1'b1, 1, 1, 1, 1'b1, 2, 1'b0);
      run_seq("R11 tie met at limit", 2'd1, 1'b0, T_CYC, 1, 1, 1'b1, 2, 1'b0);
      run_seq("R11 one past limit", 2'd1, 1'b0, T_CYC + 1, 1, 1, 1'b1, 0, 1'b0);
      repeat (30) @(negedge clk);
      check(error == 1'b1, "R12 error held", int'(error), 1);
      run_seq("R9 final poll timeout", 2'd2, 1'b0, 1, 1, 1000, 1'b0, 1, 1'b0);
      run_seq("R13 restart ignored", 2'd2, 1'b0, 4, 4, 4, 1'b1, 2, 1'b1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule